// File: doc/BRIEF.md
# PS/2 Keyboard Scan Code Receiver

This block listens to the two open-collector lines of a PS/2 keyboard, a serial clock and a serial data line, and presents a received scan code as an 8-bit parallel word. Both lines rest at logic 1. The keyboard shifts out 11-bit frames: a start bit of 0, eight data bits with the least significant bit first, a parity bit and a stop bit of 1. Each data bit is valid on a falling edge of the keyboard clock. Pressing a key sends one frame carrying the make code. Releasing the key sends a break-prefix frame and then a frame carrying the key's code.

The receiver treats one key event as a fixed run of three frames, or 33 bits. It updates its output only after the 33rd bit. It is built as a datapath and a separate control state machine. The datapath holds the input synchronizers, an 11-bit shift register, a bit counter and the output register. The control unit sequences these blocks from a single "all bits received" status flag.

The output side has no back-pressure. The consumer treats `busy_out` low as "`code_out` is valid". The word stays on `code_out` until the next complete 33-bit event replaces it.

Top module: `ps2_scan_rx`

## Requirements
- R1: A synchronous reset, sampled high on a rising `clk` edge, sets `code_out` to 8'h00 and `busy_out` to 0.
- R2: While the keyboard clock line stays at 1, `busy_out` stays 0 and `code_out` keeps its value.
- R3: `busy_out` rises within 6 `clk` cycles after the keyboard clock line first goes low in an event.
- R4: `busy_out` stays 1 through all 33 bits of an event, including the idle gaps between its frames. It falls only after the 33rd bit has been counted.
- R5: `code_out` changes only when an event completes. After one or two frames, it still holds the previous code.
- R6: After an event, `code_out` holds the eight data bits of the third frame. Bit 0 is the first bit sent after the start bit, and the parity and stop bits are discarded.
- R7: `busy_out` falls in the same cycle that the new code appears on `code_out`. From then on, a low `busy_out` marks a valid code.
- R8: The data line is sampled only while the keyboard clock is low. Any change on the data line while the keyboard clock is high has no effect on the received code.
- R9: Asserting reset in the middle of an event abandons that event. Afterwards a complete new event is received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| kbd_clk_in | input | 1 | Keyboard serial clock line, idle 1, asynchronous |
| kbd_dat_in | input | 1 | Keyboard serial data line, idle 1, asynchronous |
| code_out | output | 8 | Received scan code of the last completed event |
| busy_out | output | 1 | 1 while an event is being received, 0 when code_out is valid |

## Verification
The checker monitors three rules on every cycle:
- `code_out` may change only in the cycle that `busy_out` falls.
- `busy_out` may fall only after the bit counter reached 33.
- The counter advances only after the synchronized keyboard clock was low.

The checker also confirms that the counter never passes 33 and that reset always clears the outputs.

Some properties need the bench's scenarios, because they depend on frame contents. These are:
- whether the byte taken is the third frame's data in the right bit order;
- whether data-line glitches during the clock's high phase are ignored;
- whether the old code survives a partial event;
- whether an event interrupted by reset leaves the receiver ready for the next one.

// File: rtl/ps2_scan_pkg.sv
package ps2_scan_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_WAIT_LOW  = 3'd1,
    ST_SHIFT     = 3'd2,
    ST_WAIT_HIGH = 3'd3,
    ST_DONE      = 3'd4
  } rx_state_t;

  typedef struct packed {
    logic shift_en;
    logic cnt_clr;
    logic cnt_inc;
    logic load_out;
  } rx_ctrl_t;

endpackage

// File: rtl/ps2_sync.sv
module ps2_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '1;
    else     stg[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '1;
      else     stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/ps2_scan_dp.sv
module ps2_scan_dp
  import ps2_scan_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int FRAME_BITS = 11,
  parameter int FRAMES     = 3,
  localparam int TOTAL     = FRAME_BITS * FRAMES,
  localparam int CW        = $clog2(TOTAL + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 dat_s,
  input  rx_ctrl_t             ctrl,
  output logic                 cnt_done,
  output logic [CW-1:0]        cnt,
  output logic [DATA_BITS-1:0] code
);

  logic [FRAME_BITS-1:0] sreg;

  // newest bit enters at the top, older bits move toward bit 0
  always_ff @(posedge clk) begin
    if (rst)               sreg <= '0;
    else if (ctrl.shift_en) sreg <= {dat_s, sreg[FRAME_BITS-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (ctrl.cnt_clr) cnt <= '0;
    else if (ctrl.cnt_inc) cnt <= cnt + 1'b1;
  end

  assign cnt_done = (cnt == CW'(TOTAL));

  // after the last frame: bit0 = start, bits DATA_BITS..1 = data, top = stop
  always_ff @(posedge clk) begin
    if (rst)                code <= '0;
    else if (ctrl.load_out) code <= sreg[DATA_BITS:1];
  end

endmodule

// File: rtl/ps2_scan_ctrl.sv
module ps2_scan_ctrl
  import ps2_scan_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     kclk_s,
  input  logic     cnt_done,
  output rx_ctrl_t ctrl,
  output logic     busy
);

  rx_state_t state, nxt;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  always_comb begin
    nxt  = state;
    ctrl = '0;
    unique case (state)
      ST_IDLE: begin
        ctrl.cnt_clr = 1'b1;
        if (!kclk_s) nxt = ST_SHIFT;
      end
      ST_WAIT_LOW: begin
        if (!kclk_s) nxt = ST_SHIFT;
      end
      ST_SHIFT: begin
        ctrl.shift_en = 1'b1;
        ctrl.cnt_inc  = 1'b1;
        nxt           = ST_WAIT_HIGH;
      end
      ST_WAIT_HIGH: begin
        if (kclk_s) nxt = cnt_done ? ST_DONE : ST_WAIT_LOW;
      end
      ST_DONE: begin
        ctrl.load_out = 1'b1;
        nxt           = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/ps2_scan_rx.sv
module ps2_scan_rx
  import ps2_scan_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int FRAME_BITS  = 11,
  parameter int FRAMES      = 3,
  parameter int SYNC_STAGES = 2,
  localparam int TOTAL      = FRAME_BITS * FRAMES,
  localparam int CW         = $clog2(TOTAL + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 kbd_clk_in,
  input  logic                 kbd_dat_in,
  output logic [DATA_BITS-1:0] code_out,
  output logic                 busy_out
);

  logic          kclk_s;
  logic          kdat_s;
  logic          cnt_done;
  logic [CW-1:0] bit_cnt;
  rx_ctrl_t      ctrl;

  ps2_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({kbd_clk_in, kbd_dat_in}),
    .dout ({kclk_s, kdat_s})
  );

  ps2_scan_dp #(
    .DATA_BITS (DATA_BITS),
    .FRAME_BITS(FRAME_BITS),
    .FRAMES    (FRAMES)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .dat_s   (kdat_s),
    .ctrl    (ctrl),
    .cnt_done(cnt_done),
    .cnt     (bit_cnt),
    .code    (code_out)
  );

  ps2_scan_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .kclk_s  (kclk_s),
    .cnt_done(cnt_done),
    .ctrl    (ctrl),
    .busy    (busy_out)
  );

endmodule

// File: rtl/ps2_scan_rx_chk.sv
module ps2_scan_rx_chk #(
  parameter int DATA_BITS = 8,
  parameter int TOTAL     = 33,
  parameter int CW        = 6
) (
  input logic                 clk,
  input logic                 rst,
  input logic [DATA_BITS-1:0] code,
  input logic                 busy,
  input logic [CW-1:0]        bit_cnt,
  input logic                 clk_sync
);

  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst_q |-> (code == '0 && !busy));  // R1

  AST_CODE_ONLY_AT_END: assert property (@(posedge clk) disable iff (rst)
    !$stable(code) |-> $fell(busy));  // R7

  AST_BUSY_FALL_FULL: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(bit_cnt) == CW'(TOTAL)));  // R4

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CW'(TOTAL));  // R5

  AST_SAMPLE_LOW: assert property (@(posedge clk) disable iff (rst)
    (bit_cnt == $past(bit_cnt) + 1'b1) |-> !$past(clk_sync, 2));  // R8

endmodule

bind ps2_scan_rx ps2_scan_rx_chk #(
  .DATA_BITS(DATA_BITS),
  .TOTAL    (TOTAL),
  .CW       (CW)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .code    (code_out),
  .busy    (busy_out),
  .bit_cnt (bit_cnt),
  .clk_sync(kclk_s)
);

// File: tb/sim_ps2_scan_rx.sv
module sim_ps2_scan_rx;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       kc  = 1'b1;
  logic       kd  = 1'b1;
  logic [7:0] code;
  logic       busy;
  int         checks = 0;
  int         fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ps2_scan_rx u0 (
    .clk       (clk),
    .rst       (rst),
    .kbd_clk_in(kc),
    .kbd_dat_in(kd),
    .code_out  (code),
    .busy_out  (busy)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // glitch: toggle data during the high phase before settling
  task automatic send_frame(input logic [7:0] b, input bit glitch, input bit chk_busy);
    logic [10:0] f;
    f = {1'b1, ~^b, b, 1'b0};
    for (int i = 0; i < 11; i++) begin
      if (glitch) begin
        kd = ~f[i]; wait_cyc(HALF/2);
        kd = f[i];  wait_cyc(HALF/2);
      end else begin
        kd = f[i];  wait_cyc(HALF);
      end
      kc = 1'b0;
      wait_cyc(HALF);
      if (chk_busy && i == 0) check("R3 busy after first fall", {7'd0, busy}, 8'd1);
      kc = 1'b1;
    end
    kd = 1'b1;
    wait_cyc(HALF);
  endtask

  task automatic t_reset();
    rst = 1'b1; wait_cyc(3); rst = 1'b0; wait_cyc(1);
    check("R1 code after reset", code, 8'h00);
    check("R1 busy after reset", {7'd0, busy}, 8'd0);
  endtask

  task automatic t_idle();
    kd = 1'b0; wait_cyc(10); kd = 1'b1; wait_cyc(30);
    check("R2 busy idle", {7'd0, busy}, 8'd0);
    check("R2 code idle", code, 8'h00);
  endtask

  task automatic t_event(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                         input logic [7:0] prev, input bit glitch);
    send_frame(a, glitch, 1'b1);
    check("R4 busy after frame 1", {7'd0, busy}, 8'd1);
    check("R5 code held after frame 1", code, prev);
    send_frame(b, glitch, 1'b0);
    check("R4 busy after frame 2", {7'd0, busy}, 8'd1);
    check("R5 code held after frame 2", code, prev);
    send_frame(c, glitch, 1'b0);
    check(glitch ? "R8 code with data glitches" : "R6 code is third frame", code, c);
    check("R7 busy low with valid code", {7'd0, busy}, 8'd0);
  endtask

  task automatic t_mid_reset();
    send_frame(8'h33, 1'b0, 1'b0);
    rst = 1'b1; wait_cyc(2); rst = 1'b0; wait_cyc(2);
    check("R9 code after mid reset", code, 8'h00);
    check("R9 busy after mid reset", {7'd0, busy}, 8'd0);
    t_event(8'h66, 8'hF0, 8'h81, 8'h00, 1'b0);
  endtask

  initial begin
    wait_cyc(200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_event(8'h1C, 8'hF0, 8'h1C, 8'h00, 1'b0);
    t_event(8'h5A, 8'hF0, 8'hA5, 8'h1C, 1'b0);
    t_event(8'h12, 8'hF0, 8'h3E, 8'hA5, 1'b1);
    wait_cyc(40);
    check("R2 code held when idle", code, 8'h3E);
    t_mid_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule